// File: doc/BRIEF.md
# Per-Pin Interrupt Detector for a Four-Port Pin Bank

This block watches the already-synchronized levels of a bank of pins, grouped as four ports of eight, and turns selected level conditions or transitions on each pin into a pending flag. Each pin has its own trigger setting: rising edge, falling edge, either edge, active-high level or active-low level. Pending flags are held in a per-port status register and gated by a per-port enable register. The OR of all enabled pending flags across the whole bank drives a single interrupt line toward the interrupt controller.

The register block in front of this detector turns bus writes into single-cycle strobes. Each strobe carries a port number, a target selector and a data word. Software arms a pin by writing its trigger setting and then its enable bit. It services the pin by writing a one to that pin's position through the clear selector. A read port selects one port and shows its status, enable and trigger setting, so the register block can return them on reads.

Top module: `pin_irq_bank`

## Requirements
- R1: A synchronous active-high reset sets every port's status, enable and trigger setting to zero and holds the interrupt line low, so nothing can interrupt before configuration.
- R2: Selector 1 loads the 24-bit trigger word of the addressed port. For pin b of that port, bit b is the polarity (1 = high/rising), bit b+8 selects edge (1) rather than level (0), and bit b+16 selects either-edge when edge mode is on. The word reads back unchanged.
- R3: Setting 0x000101 shifted left by b selects rising mode. Pin b's status bit is set when the pin was 0 in the previous cycle and is 1 now. A falling transition sets nothing.
- R4: Setting 0x000100 shifted left by b selects falling mode. The status bit is set on a 1-to-0 transition only.
- R5: Setting 0x010100 shifted left by b selects either-edge mode. Any change of the pin's level between consecutive cycles sets the status bit.
- R6: Setting 0x000001 shifted left by b selects level-high mode, and setting all three bits to 0 selects level-low mode. In a level mode the status bit is set again in every cycle that the active level is present, so a clear only sticks once the pin is inactive.
- R7: Selector 2 clears the addressed port's status bits where the data bits 7:0 are 1. Bits written as 0 leave their status unchanged.
- R8: When a clear and a new trigger event on the same pin fall in the same cycle, the status bit stays set. An event in any cycle after a clear sets the bit again.
- R9: Selector 0 loads data bits 7:0 into the addressed port's enable register. The interrupt line is high exactly when, in some port, a status bit and its enable bit are both 1.
- R10: Each cycle's detection uses the pin level from the previous cycle and the trigger setting held before that cycle's write. Status and enable changes appear after the clock edge that samples them, and the interrupt line follows them in the same cycle.
- R11: Selector 3 is a no-operation. A write strobe that carries it changes no status, enable or trigger setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl_i | input | 32 | Synchronized pin levels, port p in bits 8p+7:8p |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_sel_i | input | 2 | Target: 0 enable, 1 trigger setting, 2 clear, 3 none |
| wr_port_i | input | 2 | Port addressed by the write |
| wr_data_i | input | 24 | Write data |
| rd_port_i | input | 2 | Port shown on the read outputs |
| rd_sts_o | output | 8 | Status of the selected port |
| rd_enb_o | output | 8 | Enable of the selected port |
| rd_cfg_o | output | 24 | Trigger setting of the selected port |
| irq_o | output | 1 | Bank interrupt line |

## Verification
A clear strobe and a fresh trigger event on the same pin can land in one cycle, and so can a trigger-setting write and a pin transition that only the old or only the new setting would detect. The bench forces both pairs on purpose. It raises a pin in the same cycle that it clears that pin, and it drops a pin in the same cycle that it changes the pin from rising to falling. It then expects the status bit to survive the clear in the first case and to stay clear in the second. A randomized phase then mixes writes and pin activity freely. A behavioural model compares status, enable, setting and interrupt line against the design on every clock.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    localparam int PORT_W = 8;
    localparam int CFG_W  = 3 * PORT_W;

    // Trigger word: three planes, one bit per pin in each plane.
    typedef struct packed {
        logic [PORT_W-1:0] both;   // either-edge plane
        logic [PORT_W-1:0] edg;    // edge (1) versus level (0) plane
        logic [PORT_W-1:0] pol;    // polarity plane
    } trig_cfg_t;

    typedef enum logic [1:0] {
        SEL_ENB = 2'd0,
        SEL_CFG = 2'd1,
        SEL_CLR = 2'd2,
        SEL_NOP = 2'd3
    } wr_sel_e;

    typedef enum logic [2:0] {
        MODE_LVL_LO = 3'd0,
        MODE_LVL_HI = 3'd1,
        MODE_RISE   = 3'd2,
        MODE_FALL   = 3'd3,
        MODE_BOTH   = 3'd4
    } trig_mode_e;

    function automatic trig_mode_e mode_of(input logic pol, input logic edg, input logic both);
        trig_mode_e m;
        if (!edg)
            m = pol ? MODE_LVL_HI : MODE_LVL_LO;
        else if (both)
            m = MODE_BOTH;
        else
            m = pol ? MODE_RISE : MODE_FALL;
        return m;
    endfunction

endpackage

// File: rtl/pinirq_pin_det.sv
module pinirq_pin_det
    import pinirq_pkg::*;
(
    input  logic cur_i,
    input  logic prev_i,
    input  logic pol_i,
    input  logic edg_i,
    input  logic both_i,
    output logic hit_o
);

    trig_mode_e mode;

    always_comb begin
        mode = mode_of(pol_i, edg_i, both_i);
        unique case (mode)
            MODE_LVL_LO: hit_o = ~cur_i;
            MODE_LVL_HI: hit_o = cur_i;
            MODE_RISE:   hit_o = cur_i & ~prev_i;
            MODE_FALL:   hit_o = ~cur_i & prev_i;
            MODE_BOTH:   hit_o = cur_i ^ prev_i;
            default:     hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pinirq_port.sv
module pinirq_port
    import pinirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pin_i,
    input  logic              wr_en_i,
    input  wr_sel_e           wr_sel_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    output logic [PORT_W-1:0] sts_o,
    output logic [PORT_W-1:0] enb_o,
    output trig_cfg_t         cfg_o,
    output logic [PORT_W-1:0] pend_o
);

    logic [PORT_W-1:0] prev_q;
    logic [PORT_W-1:0] sts_q;
    logic [PORT_W-1:0] enb_q;
    trig_cfg_t         cfg_q;
    logic [PORT_W-1:0] hit;
    logic [PORT_W-1:0] clr_mask;
    logic              cfg_we;
    logic              enb_we;

    for (genvar b = 0; b < PORT_W; b++) begin : g_pin
        pinirq_pin_det u_det (
            .cur_i  (pin_i[b]),
            .prev_i (prev_q[b]),
            .pol_i  (cfg_q.pol[b]),
            .edg_i  (cfg_q.edg[b]),
            .both_i (cfg_q.both[b]),
            .hit_o  (hit[b])
        );
    end

    always_comb begin
        cfg_we   = wr_en_i && (wr_sel_i == SEL_CFG);
        enb_we   = wr_en_i && (wr_sel_i == SEL_ENB);
        clr_mask = (wr_en_i && (wr_sel_i == SEL_CLR)) ? wr_data_i[PORT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= pin_i;
            sts_q  <= '0;
            enb_q  <= '0;
            cfg_q  <= '0;
        end else begin
            prev_q <= pin_i;
            sts_q  <= (sts_q & ~clr_mask) | hit;
            if (enb_we)
                enb_q <= wr_data_i[PORT_W-1:0];
            if (cfg_we)
                cfg_q <= trig_cfg_t'(wr_data_i);
        end
    end

    assign sts_o  = sts_q;
    assign enb_o  = enb_q;
    assign cfg_o  = cfg_q;
    assign pend_o = sts_q & enb_q;

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (enb_q == '0 && cfg_q == '0 && sts_q == '0)); // R1
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_q == trig_cfg_t'($past(wr_data_i)))); // R2
    AST_ENB_LOAD: assert property (@(posedge clk) disable iff (rst)
        enb_we |=> (enb_q == $past(wr_data_i[PORT_W-1:0]))); // R9
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((sts_q & $past(clr_mask & ~hit)) == '0)); // R7
    AST_HIT_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((sts_q & $past(hit)) == $past(hit))); // R8
    AST_STS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (hit == '0 && clr_mask == '0) |=> $stable(sts_q)); // R10

endmodule

// File: rtl/pinirq_reduce.sv
module pinirq_reduce #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8
) (
    input  logic [NUM_PORTS*PORT_W-1:0] pend_i,
    output logic                        irq_o
);

    logic [NUM_PORTS-1:0] port_any;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_any[p] = |pend_i[p*PORT_W +: PORT_W];
    end

    assign irq_o = |port_any;

endmodule

// File: rtl/pin_irq_bank.sv
module pin_irq_bank
    import pinirq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int PSW      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int PIN_N    = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_N-1:0]  pin_lvl_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [PSW-1:0]    wr_port_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    input  logic [PSW-1:0]    rd_port_i,
    output logic [PORT_W-1:0] rd_sts_o,
    output logic [PORT_W-1:0] rd_enb_o,
    output logic [CFG_W-1:0]  rd_cfg_o,
    output logic              irq_o
);

    wr_sel_e           sel;
    logic [PORT_W-1:0] sts_a [NUM_PORTS];
    logic [PORT_W-1:0] enb_a [NUM_PORTS];
    trig_cfg_t         cfg_a [NUM_PORTS];
    logic [PIN_N-1:0]  pend_flat;
    logic [PIN_N-1:0]  enb_flat;

    assign sel = wr_sel_e'(wr_sel_i);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic              port_we;
        logic [PORT_W-1:0] pend_p;

        assign port_we = wr_en_i && (wr_port_i == PSW'(p));

        pinirq_port u_port (
            .clk       (clk),
            .rst       (rst),
            .pin_i     (pin_lvl_i[p*PORT_W +: PORT_W]),
            .wr_en_i   (port_we),
            .wr_sel_i  (sel),
            .wr_data_i (wr_data_i),
            .sts_o     (sts_a[p]),
            .enb_o     (enb_a[p]),
            .cfg_o     (cfg_a[p]),
            .pend_o    (pend_p)
        );

        assign pend_flat[p*PORT_W +: PORT_W] = pend_p;
        assign enb_flat[p*PORT_W +: PORT_W]  = enb_a[p];
    end

    pinirq_reduce #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_reduce (
        .pend_i (pend_flat),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_sts_o = sts_a[rd_port_i];
        rd_enb_o = enb_a[rd_port_i];
        rd_cfg_o = cfg_a[rd_port_i];
    end

    AST_IRQ_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_o); // R1
    AST_IRQ_NEEDS_ENB: assert property (@(posedge clk) disable iff (rst)
        (enb_flat == '0) |-> !irq_o); // R9

endmodule

// File: tb/pin_irq_bank_tb.sv
module pin_irq_bank_tb;

    localparam int NP = 4;
    localparam int PW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [1:0]  wr_port = '0;
    logic [23:0] wr_data = '0;
    logic [1:0]  rd_port = '0;
    logic [7:0]  rd_sts;
    logic [7:0]  rd_enb;
    logic [23:0] rd_cfg;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  m_sts  [NP];
    logic [7:0]  m_enb  [NP];
    logic [23:0] m_cfg  [NP];
    logic [7:0]  m_prev [NP];

    always #2 clk = ~clk;

    pin_irq_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .pin_lvl_i (pins),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_port_i (wr_port),
        .wr_data_i (wr_data),
        .rd_port_i (rd_port),
        .rd_sts_o  (rd_sts),
        .rd_enb_o  (rd_enb),
        .rd_cfg_o  (rd_cfg),
        .irq_o     (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on every clock and compared after it.
    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NP; p++) begin
                m_sts[p]  = '0;
                m_enb[p]  = '0;
                m_cfg[p]  = '0;
                m_prev[p] = pins[p*PW +: PW];
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                logic [7:0] h;
                logic [7:0] c;
                h = '0;
                for (int b = 0; b < PW; b++) begin
                    logic cur, pv, po, ed, bo;
                    cur = pins[p*PW+b];
                    pv  = m_prev[p][b];
                    po  = m_cfg[p][b];
                    ed  = m_cfg[p][b+8];
                    bo  = m_cfg[p][b+16];
                    if (!ed)     h[b] = (cur == po);
                    else if (bo) h[b] = (cur != pv);
                    else if (po) h[b] = cur && !pv;
                    else         h[b] = !cur && pv;
                end
                c = (wr_en && wr_port == p && wr_sel == 2'd2) ? wr_data[7:0] : 8'h00;
                m_sts[p] = (m_sts[p] & ~c) | h;
                if (wr_en && wr_port == p && wr_sel == 2'd0) m_enb[p] = wr_data[7:0];
                if (wr_en && wr_port == p && wr_sel == 2'd1) m_cfg[p] = wr_data;
                m_prev[p] = pins[p*PW +: PW];
            end
        end
        #1;
        begin
            logic any;
            any = 1'b0;
            for (int p = 0; p < NP; p++) any = any | (|(m_sts[p] & m_enb[p]));
            chk("R9 model irq", {31'd0, irq}, {31'd0, any});
            chk("R10 model status", {24'd0, rd_sts}, {24'd0, m_sts[rd_port]});
            chk("R9 model enable", {24'd0, rd_enb}, {24'd0, m_enb[rd_port]});
            chk("R2 model setting", {8'd0, rd_cfg}, {8'd0, m_cfg[rd_port]});
        end
    end

    // Drive at the falling edge; return just after the next rising edge.
    task automatic step(input logic [31:0] pv, input logic we, input logic [1:0] sel,
                        input logic [1:0] port, input logic [23:0] data, input logic [1:0] rp);
        @(negedge clk);
        pins    = pv;
        wr_en   = we;
        wr_sel  = sel;
        wr_port = port;
        wr_data = data;
        rd_port = rp;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic [1:0] rp);
        step(pins, 1'b0, 2'd0, 2'd0, 24'd0, rp);
    endtask

    initial begin
        logic [31:0] p;
        p = '0;
        step(p, 0, 0, 0, 0, 0);
        step(p, 0, 0, 0, 0, 0);
        chk("R1 status", {24'd0, rd_sts}, 32'h0);
        chk("R1 enable", {24'd0, rd_enb}, 32'h0);
        chk("R1 setting", {8'd0, rd_cfg}, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        for (int q = 0; q < NP; q++) step(p, 1, 2'd1, 2'(q), 24'h00FFFF, 0);
        for (int q = 0; q < NP; q++) step(p, 1, 2'd2, 2'(q), 24'h0000FF, 0);
        chk("R7 all cleared", {24'd0, rd_sts}, 32'h0);
        chk("R2 rising word", {8'd0, rd_cfg}, 32'h00FFFF);

        // R3 rising
        p[0] = 1'b1; step(p, 0, 0, 0, 0, 0);
        chk("R3 rise sets", {24'd0, rd_sts}, 32'h01);
        step(p, 1, 2'd2, 0, 24'h01, 0);
        chk("R7 clear", {24'd0, rd_sts}, 32'h00);
        p[0] = 1'b0; step(p, 0, 0, 0, 0, 0);
        chk("R3 fall ignored", {24'd0, rd_sts}, 32'h00);

        // R4 falling on pin 1
        step(p, 1, 2'd1, 0, 24'h00FFFD, 0);
        chk("R2 falling word", {8'd0, rd_cfg}, 32'h00FFFD);
        p[1] = 1'b1; step(p, 0, 0, 0, 0, 0);
        chk("R4 rise ignored", {24'd0, rd_sts}, 32'h00);
        p[1] = 1'b0; step(p, 0, 0, 0, 0, 0);
        chk("R4 fall sets", {24'd0, rd_sts}, 32'h02);
        step(p, 1, 2'd2, 0, 24'h01, 0);
        chk("R7 zero bits keep", {24'd0, rd_sts}, 32'h02);
        step(p, 1, 2'd2, 0, 24'h02, 0);
        chk("R7 clear bit1", {24'd0, rd_sts}, 32'h00);

        // R5 either edge on port 1 pin 3
        step(p, 1, 2'd1, 1, 24'h08FFFF, 1);
        p[11] = 1'b1; step(p, 0, 0, 0, 0, 1);
        chk("R5 rise sets", {24'd0, rd_sts}, 32'h08);
        step(p, 1, 2'd2, 1, 24'h08, 1);
        p[11] = 1'b0; step(p, 0, 0, 0, 0, 1);
        chk("R5 fall sets", {24'd0, rd_sts}, 32'h08);
        step(p, 1, 2'd2, 1, 24'h08, 1);
        chk("R7 port1 clear", {24'd0, rd_sts}, 32'h00);

        // R6 level high on port 2 pin 0, level low on pin 1
        step(p, 1, 2'd1, 2, 24'h00FEFF, 2);
        idle(2);
        chk("R6 inactive high", {24'd0, rd_sts}, 32'h00);
        p[16] = 1'b1; step(p, 0, 0, 0, 0, 2);
        chk("R6 high sets", {24'd0, rd_sts}, 32'h01);
        step(p, 1, 2'd2, 2, 24'h01, 2);
        chk("R6 clear while active", {24'd0, rd_sts}, 32'h01);
        p[16] = 1'b0; step(p, 1, 2'd2, 2, 24'h01, 2);
        chk("R6 clear when inactive", {24'd0, rd_sts}, 32'h00);
        step(p, 1, 2'd1, 2, 24'h00FCFD, 2);
        idle(2);
        chk("R6 low sets", {24'd0, rd_sts}, 32'h02);
        p[17] = 1'b1; step(p, 1, 2'd2, 2, 24'h02, 2);
        chk("R6 low clear", {24'd0, rd_sts}, 32'h00);

        // R8 clear and new edge together
        p[0] = 1'b1; step(p, 1, 2'd2, 0, 24'h01, 0);
        chk("R8 edge beats clear", {24'd0, rd_sts}, 32'h01);
        step(p, 1, 2'd2, 0, 24'h01, 0);
        p[0] = 1'b0; step(p, 0, 0, 0, 0, 0);
        chk("R8 cleared", {24'd0, rd_sts}, 32'h00);
        p[0] = 1'b1; step(p, 0, 0, 0, 0, 0);
        chk("R8 later edge sets", {24'd0, rd_sts}, 32'h01);

        // R9 enable gating and bank OR
        step(p, 1, 2'd0, 0, 24'h01, 0);
        chk("R9 enable read", {24'd0, rd_enb}, 32'h01);
        chk("R9 irq up", {31'd0, irq}, 32'h1);
        step(p, 1, 2'd2, 0, 24'h01, 0);
        chk("R9 irq down", {31'd0, irq}, 32'h0);
        p[24] = 1'b1; step(p, 0, 0, 0, 0, 3);
        chk("R9 pending port3", {24'd0, rd_sts}, 32'h01);
        chk("R9 disabled no irq", {31'd0, irq}, 32'h0);
        step(p, 1, 2'd0, 3, 24'h01, 3);
        chk("R9 port3 irq", {31'd0, irq}, 32'h1);
        step(p, 1, 2'd0, 3, 24'h00, 3);
        chk("R9 masked irq", {31'd0, irq}, 32'h0);
        chk("R9 status kept", {24'd0, rd_sts}, 32'h01);

        // R11 selector 3
        step(p, 1, 2'd3, 3, 24'hFFFFFF, 3);
        chk("R11 status", {24'd0, rd_sts}, 32'h01);
        chk("R11 enable", {24'd0, rd_enb}, 32'h00);
        chk("R11 setting", {8'd0, rd_cfg}, 32'h00FFFF);

        // R10 detection uses the setting held before the write
        p[2] = 1'b1; step(p, 0, 0, 0, 0, 0);
        chk("R3 pin2 rise", {24'd0, rd_sts}, 32'h04);
        step(p, 1, 2'd2, 0, 24'h04, 0);
        p[2] = 1'b0; step(p, 1, 2'd1, 0, 24'h00FFF9, 0);
        chk("R10 old setting used", {24'd0, rd_sts}, 32'h00);
        p[2] = 1'b1; step(p, 0, 0, 0, 0, 0);
        chk("R10 new falling ignores rise", {24'd0, rd_sts}, 32'h00);
        p[2] = 1'b0; step(p, 0, 0, 0, 0, 0);
        chk("R10 new falling sets", {24'd0, rd_sts}, 32'h04);

        // Random mix, judged by the reference model every clock
        for (int i = 0; i < 4000; i++) begin
            step($urandom, ($urandom % 3) != 0, 2'($urandom), 2'($urandom),
                 24'($urandom), 2'($urandom));
        end
        @(negedge clk);
        wr_en = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule